// File: doc/BRIEF.md
# Multi-Channel DDR Sample Serializer

This block takes eight parallel 14-bit converter samples and shifts them out on eight serial data lanes. Each fast clock cycle carries two bits per lane: one meant for the rising edge and one for the falling edge. A frame marker shows where each word starts. A pulse on the sample-valid strobe loads a new set of samples and starts a word period. The fast clock is expected to run at a fixed multiple of the sample rate. That multiple depends on the selected word width and on whether lanes are shared.

The width select sets the word size on the wire. It can drop the two least significant bits, pass the sample through unchanged, or append two zero bits below the least significant bit. When lane sharing is on, channel pairs are interleaved onto four fixed lanes, the sample period doubles in fast cycles, and the four unused lanes stay low. Lanes and channels are numbered from 0 in the port bit order.

Top module: `ddr_adc_serializer`

## Requirements
- R1: Each fast cycle puts two consecutive stream bits on a lane. The earlier bit appears on `lane_rise_o` and the next one on `lane_fall_o`. Words go out MSB first.
- R2: With `rate_sel_i` = 2'b11, each word is bits [13:2] of the sample (12 bits) and lasts 6 fast cycles.
- R3: With `rate_sel_i` = 2'b00, each word is the 14-bit sample unchanged and lasts 7 fast cycles.
- R4: With `rate_sel_i` = 2'b01, each word is the sample followed by two zero bits (16 bits) and lasts 8 fast cycles.
- R5: Code 2'b10 behaves exactly like 2'b00.
- R6: With `share_en_i` = 0, lane n carries channel n, and one sample period lasts one word.
- R7: With `share_en_i` = 1, lane 2 carries channel 0 then channel 1, lane 3 carries channels 2 then 3, lane 4 carries channels 4 then 5, and lane 5 carries channels 6 then 7. The sample period then lasts two words.
- R8: With sharing on, lanes 0, 1, 6 and 7 stay 0 for the whole period.
- R9: `frame_o` is high for the first floor(C/2) cycles of every word, where C is the number of fast cycles per word. In shared mode this gives two pulses per period.
- R10: Width and sharing are captured in the cycle the strobe is seen. Later changes have no effect until the next strobe.
- R11: A strobe seen during a period aborts that period, and the new word starts on the next cycle. A strobe in the last cycle of a period gives gap-free output.
- R12: While no period is running, including after reset, all lane outputs and `frame_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | fast bit clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| sample_valid_i | input | 1 | load samples and start a period |
| samples_i | input | NUM_CH*SAMPLE_W | packed samples, channel 0 in the low bits |
| rate_sel_i | input | 2 | word width select |
| share_en_i | input | 1 | two channels per lane |
| lane_rise_o | output | NUM_CH | rising-edge bit per lane |
| lane_fall_o | output | NUM_CH | falling-edge bit per lane |
| frame_o | output | 1 | word start marker |

## Verification
The bench uses the defaults, NUM_CH = 8 and SAMPLE_W = 14. At this size all four channel pairs are remapped and all four idle lanes are present. Every width code is reached, including the reserved one, with and without sharing, so the shared stream goes up to its full 32 bits. The directed cases also cover a width or sharing change in the middle of a period, a strobe that cuts a period short, and a strobe in the last cycle of a period.

// File: rtl/ddr_ser_pkg.sv
`timescale 1ns/1ps
package ddr_ser_pkg;
  typedef enum logic [1:0] {
    RATE_W14  = 2'b00,
    RATE_W16  = 2'b01,
    RATE_RSVD = 2'b10,
    RATE_W12  = 2'b11
  } rate_e;

  function automatic int unsigned word_bits(input logic [1:0] rate, input int unsigned sample_w);
    case (rate)
      RATE_W12: return sample_w - 2;
      RATE_W16: return sample_w + 2;
      default:  return sample_w;
    endcase
  endfunction
endpackage

// File: rtl/ddr_ser_word_fmt.sv
`timescale 1ns/1ps
module ddr_ser_word_fmt
  import ddr_ser_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  localparam int WORD_MAX = SAMPLE_W + 2
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [1:0]          rate_i,
  output logic [WORD_MAX-1:0] word_o
);
  // right-aligned word, width given by rate
  always_comb begin
    case (rate_i)
      RATE_W12: word_o = {4'b0000, sample_i[SAMPLE_W-1:2]};
      RATE_W16: word_o = {sample_i, 2'b00};
      default:  word_o = {2'b00, sample_i};
    endcase
  end
endmodule

// File: rtl/ddr_ser_lane_map.sv
`timescale 1ns/1ps
module ddr_ser_lane_map
  import ddr_ser_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 14,
  localparam int WORD_MAX = SAMPLE_W + 2,
  localparam int SR_W     = 2 * WORD_MAX
) (
  input  logic [NUM_CH*WORD_MAX-1:0] words_i,
  input  logic [1:0]                 rate_i,
  input  logic                       share_i,
  output logic [NUM_CH*SR_W-1:0]     load_o
);
  localparam int SH_BASE  = NUM_CH / 4;
  localparam int SH_LANES = NUM_CH / 2;

  logic [7:0] wbits;
  assign wbits = 8'(word_bits(rate_i, SAMPLE_W));

  // place word in slot 0 or 1 of a left-aligned stream
  function automatic logic [SR_W-1:0] place(input logic [WORD_MAX-1:0] w,
                                            input logic [7:0] bits,
                                            input int slot);
    logic [SR_W-1:0] ext;
    ext = SR_W'(w);
    return ext << (SR_W - int'(bits) * (slot + 1));
  endfunction

  for (genvar l = 0; l < NUM_CH; l++) begin : g_lane
    if (l >= SH_BASE && l < SH_BASE + SH_LANES) begin : g_shared
      localparam int A = 2 * (l - SH_BASE);
      always_comb begin
        if (share_i)
          load_o[l*SR_W +: SR_W] = place(words_i[A*WORD_MAX +: WORD_MAX], wbits, 0)
                                 | place(words_i[(A+1)*WORD_MAX +: WORD_MAX], wbits, 1);
        else
          load_o[l*SR_W +: SR_W] = place(words_i[l*WORD_MAX +: WORD_MAX], wbits, 0);
      end
    end else begin : g_solo
      always_comb begin
        if (share_i) load_o[l*SR_W +: SR_W] = '0;
        else         load_o[l*SR_W +: SR_W] = place(words_i[l*WORD_MAX +: WORD_MAX], wbits, 0);
      end
    end
  end
endmodule

// File: rtl/ddr_ser_frame_ctrl.sv
`timescale 1ns/1ps
module ddr_ser_frame_ctrl
  import ddr_ser_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  localparam int WORD_MAX = SAMPLE_W + 2,
  localparam int CNT_W    = $clog2(WORD_MAX / 2 + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] rate_i,
  input  logic       share_i,
  output logic       busy_o,
  output logic       frame_o
);
  logic [CNT_W-1:0] cyc_q, per_word_q, per_word_d;
  logic             busy_q, second_q, pair_q;

  assign per_word_d = CNT_W'(word_bits(rate_i, SAMPLE_W) / 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cyc_q      <= '0;
      per_word_q <= '0;
      second_q   <= 1'b0;
      pair_q     <= 1'b0;
    end else if (start_i) begin
      busy_q     <= 1'b1;
      cyc_q      <= '0;
      per_word_q <= per_word_d;
      second_q   <= 1'b0;
      pair_q     <= share_i;
    end else if (busy_q) begin
      if (cyc_q == per_word_q - CNT_W'(1)) begin
        cyc_q    <= '0;
        second_q <= 1'b1;
        if (second_q == pair_q) busy_q <= 1'b0;
      end else begin
        cyc_q <= cyc_q + CNT_W'(1);
      end
    end
  end

  assign busy_o  = busy_q;
  assign frame_o = busy_q && (cyc_q < (per_word_q >> 1));
endmodule

// File: rtl/ddr_ser_lane_shift.sv
`timescale 1ns/1ps
module ddr_ser_lane_shift #(
  parameter int SR_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SR_W-1:0] data_i,
  output logic            rise_o,
  output logic            fall_o
);
  logic [SR_W-1:0] sr_q;

  // zero fill: lane drains to 0 once the stream is out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= data_i;
    else             sr_q <= {sr_q[SR_W-3:0], 2'b00};
  end

  assign rise_o = sr_q[SR_W-1];
  assign fall_o = sr_q[SR_W-2];
endmodule

// File: rtl/ddr_adc_serializer.sv
`timescale 1ns/1ps
module ddr_adc_serializer
  import ddr_ser_pkg::*;
#(
  parameter int NUM_CH   = 8,   // multiple of 4
  parameter int SAMPLE_W = 14   // even
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sample_valid_i,
  input  logic [NUM_CH*SAMPLE_W-1:0]   samples_i,
  input  logic [1:0]                   rate_sel_i,
  input  logic                         share_en_i,
  output logic [NUM_CH-1:0]            lane_rise_o,
  output logic [NUM_CH-1:0]            lane_fall_o,
  output logic                         frame_o
);
  localparam int WORD_MAX = SAMPLE_W + 2;
  localparam int SR_W     = 2 * WORD_MAX;

  logic [NUM_CH*WORD_MAX-1:0] words;
  logic [NUM_CH*SR_W-1:0]     lane_load;
  logic                       busy;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_fmt
    ddr_ser_word_fmt #(.SAMPLE_W(SAMPLE_W)) i_fmt (
      .sample_i (samples_i[c*SAMPLE_W +: SAMPLE_W]),
      .rate_i   (rate_sel_i),
      .word_o   (words[c*WORD_MAX +: WORD_MAX])
    );
  end

  ddr_ser_lane_map #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) i_map (
    .words_i (words),
    .rate_i  (rate_sel_i),
    .share_i (share_en_i),
    .load_o  (lane_load)
  );

  ddr_ser_frame_ctrl #(.SAMPLE_W(SAMPLE_W)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sample_valid_i),
    .rate_i  (rate_sel_i),
    .share_i (share_en_i),
    .busy_o  (busy),
    .frame_o (frame_o)
  );

  for (genvar l = 0; l < NUM_CH; l++) begin : g_sh
    ddr_ser_lane_shift #(.SR_W(SR_W)) i_shift (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (sample_valid_i),
      .data_i (lane_load[l*SR_W +: SR_W]),
      .rise_o (lane_rise_o[l]),
      .fall_o (lane_fall_o[l])
    );
  end
endmodule

// File: rtl/ddr_ser_chk.sv
`timescale 1ns/1ps
module ddr_ser_chk
  import ddr_ser_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_valid_i,
  input logic [1:0]        rate_sel_i,
  input logic              share_en_i,
  input logic [NUM_CH-1:0] lane_rise_o,
  input logic [NUM_CH-1:0] lane_fall_o,
  input logic              frame_o,
  input logic              busy_i
);
  localparam int SH_BASE = NUM_CH / 4;

  logic [NUM_CH-1:0] idle_mask;
  logic [7:0]        run_len, exp_len;
  logic              shr_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_mask
    assign idle_mask[g] = (g >= SH_BASE && g < SH_BASE + NUM_CH/2) ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len <= '0;
      exp_len <= '0;
      shr_q   <= 1'b0;
    end else if (sample_valid_i) begin
      run_len <= '0;
      exp_len <= 8'((word_bits(rate_sel_i, SAMPLE_W) / 2) * (share_en_i ? 2 : 1));
      shr_q   <= share_en_i;
    end else if (busy_i) begin
      run_len <= run_len + 8'd1;
    end
  end

  AST_START_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> busy_i && frame_o); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (lane_rise_o == '0) && (lane_fall_o == '0) && !frame_o); // R12
  AST_SHARE_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && shr_q |-> ((lane_rise_o | lane_fall_o) & idle_mask) == '0); // R8
  AST_PERIOD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> run_len == exp_len); // R7
  AST_FRAME_TAIL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> !$past(frame_o)); // R9
endmodule

bind ddr_adc_serializer ddr_ser_chk #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) i_ddr_ser_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .rate_sel_i     (rate_sel_i),
  .share_en_i     (share_en_i),
  .lane_rise_o    (lane_rise_o),
  .lane_fall_o    (lane_fall_o),
  .frame_o        (frame_o),
  .busy_i         (busy)
);

// File: tb/test_ddr_adc_serializer.sv
`timescale 1ns/1ps
module test_ddr_adc_serializer;
  localparam int NUM_CH = 8;
  localparam int SAMPLE_W = 14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_valid_i = 1'b0;
  logic [NUM_CH*SAMPLE_W-1:0] samples_i = '0;
  logic [1:0] rate_sel_i = 2'b00;
  logic share_en_i = 1'b0;
  logic [NUM_CH-1:0] lane_rise_o, lane_fall_o;
  logic frame_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [NUM_CH-1:0] cap_r [32];
  logic [NUM_CH-1:0] cap_f [32];
  logic cap_fr [32];

  always #10 clk = ~clk;

  ddr_adc_serializer #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) i_ddr_adc_serializer (
    .clk_i(clk), .rst_ni, .sample_valid_i, .samples_i, .rate_sel_i, .share_en_i,
    .lane_rise_o, .lane_fall_o, .frame_o
  );

  function automatic int wbits(logic [1:0] r);
    if (r == 2'b11) return 12;
    if (r == 2'b01) return 16;
    return 14;
  endfunction

  function automatic logic [31:0] word_of(logic [NUM_CH*SAMPLE_W-1:0] s, int ch, logic [1:0] r);
    logic [31:0] raw;
    raw = 32'(s[ch*SAMPLE_W +: SAMPLE_W]);
    if (r == 2'b11) return raw >> 2;
    if (r == 2'b01) return raw << 2;
    return raw;
  endfunction

  function automatic logic [31:0] exp_stream(int lane, logic [1:0] r, logic sh,
                                             logic [NUM_CH*SAMPLE_W-1:0] s);
    int w;
    w = wbits(r);
    if (!sh) return word_of(s, lane, r) << (32 - w);
    if (lane >= 2 && lane <= 5)
      return (word_of(s, 2*(lane-2), r) << (32 - w)) | (word_of(s, 2*(lane-2)+1, r) << (32 - 2*w));
    return 32'h0;
  endfunction

  function automatic logic [NUM_CH*SAMPLE_W-1:0] mk(int seed);
    logic [NUM_CH*SAMPLE_W-1:0] s;
    for (int ch = 0; ch < NUM_CH; ch++)
      s[ch*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(seed*1237 + ch*2731 + ch*ch*97);
    return s;
  endfunction

  function automatic int period(logic [1:0] r, logic sh);
    return (wbits(r) / 2) * (sh ? 2 : 1);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic launch(logic [NUM_CH*SAMPLE_W-1:0] s, logic [1:0] r, logic sh);
    samples_i = s; rate_sel_i = r; share_en_i = sh; sample_valid_i = 1'b1;
  endtask

  task automatic capture(int n, bit scramble);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (c == 0) begin
        sample_valid_i = 1'b0;
        if (scramble) begin
          rate_sel_i = ~rate_sel_i; share_en_i = ~share_en_i; samples_i = ~samples_i;
        end
      end
      cap_r[c] = lane_rise_o; cap_f[c] = lane_fall_o; cap_fr[c] = frame_o;
    end
  endtask

  task automatic verify(string req, logic [NUM_CH*SAMPLE_W-1:0] s, logic [1:0] r, logic sh);
    int n, per;
    logic [31:0] act, efr;
    n = period(r, sh);
    per = wbits(r) / 2;
    for (int l = 0; l < NUM_CH; l++) begin
      act = '0;
      for (int c = 0; c < n; c++) begin
        act[31-2*c] = cap_r[c][l];
        act[30-2*c] = cap_f[c][l];
      end
      chk(req, $sformatf("lane%0d stream", l), act, exp_stream(l, r, sh, s));
    end
    act = '0; efr = '0;
    for (int c = 0; c < n; c++) begin
      act[c] = cap_fr[c];
      efr[c] = ((c % per) < per / 2);
    end
    chk("R9", "frame pattern", act, efr);
  endtask

  task automatic idle_check(string req);
    @(negedge clk);
    chk(req, "idle lanes", {15'b0, frame_o, lane_rise_o, lane_fall_o}, 32'h0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R12", "outputs in reset", {15'b0, frame_o, lane_rise_o, lane_fall_o}, 32'h0);
    rst_ni = 1'b1;
    idle_check("R12");
  endtask

  task automatic t_word(string req, logic [1:0] r, logic sh, logic [NUM_CH*SAMPLE_W-1:0] s);
    @(negedge clk);
    launch(s, r, sh);
    capture(period(r, sh), 1'b0);
    verify(req, s, r, sh);
    idle_check("R12");
  endtask

  task automatic t_config_hold();
    logic [NUM_CH*SAMPLE_W-1:0] s;
    s = mk(11);
    @(negedge clk);
    launch(s, 2'b00, 1'b0);
    capture(period(2'b00, 1'b0), 1'b1);
    verify("R10", s, 2'b00, 1'b0);
    idle_check("R10");
  endtask

  task automatic t_back_to_back();
    logic [NUM_CH*SAMPLE_W-1:0] a, b;
    a = mk(21); b = mk(22);
    @(negedge clk);
    launch(a, 2'b01, 1'b0);
    capture(period(2'b01, 1'b0), 1'b0);
    verify("R11 first", a, 2'b01, 1'b0);
    launch(b, 2'b11, 1'b1);
    capture(period(2'b11, 1'b1), 1'b0);
    verify("R11 seamless", b, 2'b11, 1'b1);
    idle_check("R11");
  endtask

  task automatic t_restart();
    logic [NUM_CH*SAMPLE_W-1:0] a, b;
    a = mk(31); b = mk(32);
    @(negedge clk);
    launch(a, 2'b01, 1'b1);
    capture(2, 1'b0);
    launch(b, 2'b11, 1'b0);
    capture(period(2'b11, 1'b0), 1'b0);
    verify("R11 restart", b, 2'b11, 1'b0);
    idle_check("R11");
  endtask

  initial begin
    t_reset();
    t_word("R3 R1 R6", 2'b00, 1'b0, mk(1));
    t_word("R2 R6", 2'b11, 1'b0, mk(2));
    t_word("R4 R6", 2'b01, 1'b0, mk(3));
    t_word("R5", 2'b10, 1'b0, mk(4));
    t_word("R7", 2'b00, 1'b1, mk(5));
    t_word("R7 R8", 2'b11, 1'b1, mk(6));
    t_word("R8 R4", 2'b01, 1'b1, '1);
    t_word("R1", 2'b01, 1'b0, '1);
    t_word("R5 R7", 2'b10, 1'b1, mk(7));
    t_config_hold();
    t_back_to_back();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule